// File: doc/BRIEF.md
# Single-Outstanding Interrupt Request Arbiter

The block gathers 64 level-sensitive interrupt lines and presents at most one request at a time to the processor, as a one-hot 64-bit vector. Lines 0 to 31 come from bus slots and lines 32 to 63 from on-board devices. Each line is gated by an enable bit in a mapping register. Bus-slot lines share one mapping register per group of four. Each on-board line has its own mapping register.

Once a request is granted it stays in place until software retires it. Software can retire it in two ways: by writing a clear register that covers it, or by writing its mapping register with every writable bit zero. When the block is idle it grants the lowest-numbered line that is pending and enabled. Bus-slot lines therefore always win over on-board lines. A line that drops after its grant does not withdraw the request.

Top module: `irq_req_arbiter`

## Requirements
- R1: Reset clears the pending vector, clears every mapping enable (bit 31) and leaves no request, so `req_onehot_o` is zero.
- R2: With no request outstanding, a pending line whose enable is set is granted. `req_onehot_o` shows bit n for line n on the second rising edge after the line is sampled high.
- R3: When several pending lines are enabled, the lowest-numbered one is granted. This places all bus-slot lines (0..31) ahead of on-board lines (32..63).
- R4: At most one bit of `req_onehot_o` is set. Lines that rise while a request is outstanding do not change the output.
- R5: A line that falls after its grant does not withdraw the request.
- R6: A write takes effect only when `wr_addr_i[2]` is 1. Any write with bit 2 at 0 is ignored.
- R7: The bus-slot mapping register at 0xC04 + 8*g carries the enable for lines 4g..4g+3 in bit 31, for g = 0..7.
- R8: The on-board mapping register at 0x1004 + 8*i carries the enable for line 32+i in bit 31, for i = 0..31.
- R9: A mapping write whose bits 31 and 10:6 are all zero retires the request if the request belongs to that register. A write with bit 31 clear but a nonzero value in bits 10:6 only disables the line and leaves the request in place.
- R10: A write to 0x1404 + 32*g retires the request only if the request is one of lines 4g..4g+3.
- R11: A write to 0x1804 + 8*i retires the request only if the request is line 32+i.
- R12: A retiring write clears `req_onehot_o` on the edge that takes the write. The next grant, if any, appears one edge later.
- R13: A line that is pending while disabled stays pending. It is granted once its enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| irq_lines_i | input | 64 | Interrupt levels; bits 0..31 bus slots, 32..63 on-board |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 16 | Register byte offset |
| wr_data_i | input | 32 | Register write data |
| req_onehot_o | output | 64 | One-hot outstanding request, zero when idle |

## Verification
The hardest state to reach from the ports combines three things: an outstanding request, other enabled lines already pending behind it, and a retiring write that lands in the same cycle as line changes. Only this mix shows whether the retire wins and whether the rescan on the next edge picks the right line. The directed part builds such a queue by hand. It stacks bus-slot and on-board lines behind a granted line, then retires the request in turn through a wrong-group clear, a right-group clear, a disabling mapping write and a non-retiring one. The random part holds a few lines high for long stretches and issues a write in about every fourth cycle, so that retires often meet pending backlogs.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned FLD_LO   = 6;
    localparam int unsigned FLD_HI   = 10;
    localparam int unsigned FLD_W    = FLD_HI - FLD_LO + 1;
    localparam int unsigned STRIDE_B = 3;
    localparam int unsigned GRP_B    = 5;
    localparam int unsigned SEL_BIT  = 2;

    localparam logic [15:0] SLOT_MAP_BASE = 16'h0C00;
    localparam logic [15:0] BRD_MAP_BASE  = 16'h1000;
    localparam logic [15:0] SLOT_CLR_BASE = 16'h1400;
    localparam logic [15:0] BRD_CLR_BASE  = 16'h1800;

    typedef struct packed {
        logic             en;
        logic [FLD_W-1:0] fld;
    } map_ent_t;

    localparam map_ent_t MAP_RST = '{en: 1'b0, fld: '1};

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int unsigned N_LINES = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] pend_o
);

    typedef struct packed {
        logic [N_LINES-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a rise sets the bit and a fall clears it; no request is touched here
        st_d.pend = (st_q.pend | (lines_i & ~st_q.pend)) & ~(~lines_i & st_q.pend);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N_LINES = 64,
    parameter int unsigned IDX_W   = 7
) (
    input  logic [N_LINES-1:0] cand_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (hit_o) begin
            assert_pick_lowest_R3: assert (cand_i[idx_o] &&
                ((cand_i & ((N_LINES'(1) << idx_o) - N_LINES'(1))) == '0))
                else $error("picker did not choose lowest candidate");
        end
    end

endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SLOT   = 32,
    parameter int unsigned N_BRD    = 32,
    parameter int unsigned GRP_SIZE = 4,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = 7
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    input  logic [IDX_W-1:0]          req_idx_i,
    output logic [N_SLOT+N_BRD-1:0]   line_en_o,
    output logic                      retire_o
);

    localparam int unsigned N_GRP = N_SLOT / GRP_SIZE;
    localparam int unsigned GRP_W = $clog2(N_GRP);
    localparam int unsigned BRD_W = $clog2(N_BRD);

    typedef struct packed {
        map_ent_t [N_GRP-1:0] slot;
        map_ent_t [N_BRD-1:0] brd;
    } map_st_t;

    map_st_t st_d, st_q;

    logic             wr_ok;
    logic             hit_slot_map, hit_brd_map, hit_slot_clr, hit_brd_clr;
    logic [GRP_W-1:0] map_grp, clr_grp;
    logic [BRD_W-1:0] brd_sel;
    logic             wr_zero;
    map_ent_t         wr_ent;
    logic             req_is_slot, req_is_brd;
    logic [GRP_W-1:0] req_grp;
    logic [BRD_W-1:0] req_brd;
    logic             unused_bits;

    assign unused_bits = ^{wr_data_i[DATA_W-2:FLD_HI+1], wr_data_i[FLD_LO-1:0],
                           wr_addr_i[1:0]};

    always_comb begin
        wr_ok        = wr_en_i && wr_addr_i[SEL_BIT];
        hit_slot_map = wr_ok && (wr_addr_i[ADDR_W-1:6] == SLOT_MAP_BASE[ADDR_W-1:6]);
        hit_brd_map  = wr_ok && (wr_addr_i[ADDR_W-1:8] == BRD_MAP_BASE[ADDR_W-1:8]);
        hit_slot_clr = wr_ok && (wr_addr_i[ADDR_W-1:8] == SLOT_CLR_BASE[ADDR_W-1:8]);
        hit_brd_clr  = wr_ok && (wr_addr_i[ADDR_W-1:8] == BRD_CLR_BASE[ADDR_W-1:8]);
        map_grp      = wr_addr_i[STRIDE_B +: GRP_W];
        brd_sel      = wr_addr_i[STRIDE_B +: BRD_W];
        clr_grp      = wr_addr_i[GRP_B +: GRP_W];
        wr_ent       = '{en: wr_data_i[EN_BIT], fld: wr_data_i[FLD_HI:FLD_LO]};
        wr_zero      = (wr_ent == '0);

        req_is_slot  = (req_idx_i < IDX_W'(N_SLOT));
        req_is_brd   = (req_idx_i >= IDX_W'(N_SLOT)) &&
                       (req_idx_i < IDX_W'(N_SLOT + N_BRD));
        req_grp      = GRP_W'(req_idx_i / IDX_W'(GRP_SIZE));
        req_brd      = BRD_W'(req_idx_i - IDX_W'(N_SLOT));
    end

    always_comb begin
        st_d     = st_q;
        retire_o = 1'b0;
        if (hit_slot_map) begin
            st_d.slot[map_grp] = wr_ent;
            if (wr_zero && req_is_slot && (req_grp == map_grp)) retire_o = 1'b1;
        end
        if (hit_brd_map) begin
            st_d.brd[brd_sel] = wr_ent;
            if (wr_zero && req_is_brd && (req_brd == brd_sel)) retire_o = 1'b1;
        end
        if (hit_slot_clr && req_is_slot && (req_grp == clr_grp)) retire_o = 1'b1;
        if (hit_brd_clr && req_is_brd && (req_brd == brd_sel))   retire_o = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.slot <= {N_GRP{MAP_RST}};
            st_q.brd  <= {N_BRD{MAP_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < N_SLOT; gi++) begin : g_slot_en
        assign line_en_o[gi] = st_q.slot[gi / GRP_SIZE].en;
    end
    for (genvar bi = 0; bi < N_BRD; bi++) begin : g_brd_en
        assign line_en_o[N_SLOT + bi] = st_q.brd[bi].en;
    end

    assert_no_retire_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_is_slot && !req_is_brd) |-> !retire_o)
        else $error("retire while idle");

endmodule

// File: rtl/irq_req_arbiter.sv
module irq_req_arbiter #(
    parameter int unsigned N_SLOT   = 32,
    parameter int unsigned N_BRD    = 32,
    parameter int unsigned GRP_SIZE = 4,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_SLOT+N_BRD-1:0] irq_lines_i,
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       wr_addr_i,
    input  logic [DATA_W-1:0]       wr_data_i,
    output logic [N_SLOT+N_BRD-1:0] req_onehot_o
);

    localparam int unsigned N_LINES = N_SLOT + N_BRD;
    localparam int unsigned IDX_W   = $clog2(N_LINES) + 1;
    localparam logic [IDX_W-1:0] NO_REQ = IDX_W'(N_LINES + 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } req_st_t;

    req_st_t st_d, st_q;

    logic [N_LINES-1:0] pend, line_en;
    logic               retire, pick_hit, idle;
    logic [IDX_W-1:0]   pick_idx;

    irq_pend_track #(.N_LINES(N_LINES)) pend_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lines_i (irq_lines_i),
        .pend_o  (pend)
    );

    irq_map_regs #(
        .N_SLOT(N_SLOT), .N_BRD(N_BRD), .GRP_SIZE(GRP_SIZE),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) map_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .req_idx_i (st_q.idx),
        .line_en_o (line_en),
        .retire_o  (retire)
    );

    irq_prio_pick #(.N_LINES(N_LINES), .IDX_W(IDX_W)) pick_i (
        .cand_i (pend & line_en),
        .hit_o  (pick_hit),
        .idx_o  (pick_idx)
    );

    assign idle = (st_q.idx == NO_REQ);

    always_comb begin
        st_d = st_q;
        if (retire)                st_d.idx = NO_REQ;
        else if (idle && pick_hit) st_d.idx = pick_idx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.idx <= NO_REQ;
        else         st_q <= st_d;
    end

    for (genvar li = 0; li < N_LINES; li++) begin : g_onehot
        assign req_onehot_o[li] = (st_q.idx == IDX_W'(li));
    end

    assert_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(req_onehot_o))
        else $error("more than one request");

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idle && !retire) |=> $stable(req_onehot_o))
        else $error("request changed without retire");

    assert_retire_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idle && retire) |=> (req_onehot_o == '0))
        else $error("retire did not clear request");

    assert_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle && pick_hit) |=> $onehot(req_onehot_o))
        else $error("idle with candidate but no grant");

endmodule

// File: tb/irq_req_arbiter_tb_top.sv
module irq_req_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lines = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [63:0] req_oh;

    int n_checks = 0;
    int n_errors = 0;
    bit rnd_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_arbiter dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .irq_lines_i  (lines),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .req_onehot_o (req_oh)
    );

    // reference model built from the requirements
    bit [63:0] m_pend;
    bit        m_slot_en [8];
    bit        m_brd_en  [32];
    int        m_req;

    function automatic int m_pick();
        for (int i = 0; i < 64; i++) begin
            if (m_pend[i] && ((i < 32) ? m_slot_en[i/4] : m_brd_en[i-32])) return i;
        end
        return -1;
    endfunction

    function automatic logic [63:0] m_onehot();
        return (m_req < 0) ? 64'd0 : (64'd1 << m_req);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0;
            m_req  = -1;
            for (int i = 0; i < 8; i++)  m_slot_en[i] = 1'b0;
            for (int i = 0; i < 32; i++) m_brd_en[i]  = 1'b0;
        end else begin
            bit ret;
            bit zero;
            int pk;
            ret  = 1'b0;
            pk   = m_pick();
            zero = (wr_data[31] == 1'b0) && (wr_data[10:6] == 5'd0);
            if (wr_en && wr_addr[2]) begin
                case (wr_addr[15:8])
                    8'h0C: if (wr_addr[7:6] == 2'b00) begin
                        if (zero && m_req >= 0 && m_req < 32 && m_req/4 == int'(wr_addr[5:3])) ret = 1;
                        m_slot_en[wr_addr[5:3]] = wr_data[31];
                    end
                    8'h10: begin
                        if (zero && m_req == 32 + int'(wr_addr[7:3])) ret = 1;
                        m_brd_en[wr_addr[7:3]] = wr_data[31];
                    end
                    8'h14: if (m_req >= 0 && m_req < 32 && m_req/4 == int'(wr_addr[7:5])) ret = 1;
                    8'h18: if (m_req == 32 + int'(wr_addr[7:3])) ret = 1;
                    default: ;
                endcase
            end
            if (ret)                       m_req = -1;
            else if (m_req < 0 && pk >= 0) m_req = pk;
            m_pend = lines;
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [63:0] exp);
        n_checks++;
        if (req_oh !== exp) begin
            n_errors++;
            $display("FAIL %s: req_onehot_o=%h expected=%h at %0t", tag, req_oh, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; lines = '0; wr_en = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        do_reset();
        check("R1 reset idle", 64'd0);

        lines[5] = 1'b1; tick(); tick(); tick();
        check("R1 enables cleared by reset", 64'd0);
        wr(16'h0C0C, 32'h8000_0000);
        check("R2 grant not before second edge", 64'd0);
        tick();
        check("R7 R13 group 1 enable grants line 5", 64'd1 << 5);

        lines[2] = 1'b1; lines[40] = 1'b1; tick(); tick();
        wr(16'h0C04, 32'h8000_0000);
        wr(16'h1044, 32'h8000_0000);
        tick(); tick();
        check("R4 single outstanding", 64'd1 << 5);
        lines[5] = 1'b0; tick(); tick();
        check("R5 fall keeps request", 64'd1 << 5);

        wr(16'h1420, 32'h0);
        check("R6 bit2 clear ignored", 64'd1 << 5);
        wr(16'h1404, 32'h0);
        check("R10 other group clear no effect", 64'd1 << 5);
        wr(16'h1424, 32'h0);
        check("R12 retire clears at once", 64'd0);
        tick();
        check("R3 R12 slot line 2 beats line 40", 64'd1 << 2);

        wr(16'h1844, 32'h0);
        check("R11 board clear vs slot request", 64'd1 << 2);
        lines[2] = 1'b0; tick(); tick();
        wr(16'h1404, 32'h0);
        check("R10 group 0 clear retires", 64'd0);
        tick();
        check("R3 board line granted after slots empty", 64'd1 << 40);

        wr(16'h184C, 32'h0);
        check("R11 wrong board clear", 64'd1 << 40);
        wr(16'h1044, 32'h0000_0040);
        check("R9 nonzero field keeps request", 64'd1 << 40);
        wr(16'h1044, 32'h0);
        check("R9 zero mapping retires", 64'd0);
        tick(); tick();
        check("R13 disabled pending not granted", 64'd0);

        lines[63] = 1'b1;
        wr(16'h10FC, 32'h8000_0000);
        tick();
        check("R8 board map 31 grants line 63", 64'd1 << 63);
        wr(16'h10F8, 32'h0);
        check("R6 mapping write bit2 clear ignored", 64'd1 << 63);
        wr(16'h18FC, 32'h0);
        check("R11 matching board clear", 64'd0);
        tick();
        check("R12 regrant on next edge", 64'd1 << 63);

        wr(16'h1044, 32'h8000_0000);
        wr(16'h10FC, 32'h0);
        check("R9 board mapping retire", 64'd0);
        tick();
        check("R13 re-enabled line 40 granted", 64'd1 << 40);

        // random phase against the reference model
        do_reset();
        rnd_on = 1'b1;
        for (int c = 0; c < N_RAND; c++) begin
            if ($urandom % 6 == 0) begin
                int ln;
                ln = $urandom % 64;
                lines[ln] = ~lines[ln];
            end
            wr_en = 1'b0;
            if ($urandom % 4 == 0) begin
                int kind;
                int sel;
                logic [15:0] base;
                kind = $urandom % 4;
                sel  = $urandom;
                case (kind)
                    0: base = 16'h0C00 + 16'(8 * (sel % 8));
                    1: base = 16'h1000 + 16'(8 * (sel % 32));
                    2: base = 16'h1400 + 16'(32 * (sel % 8));
                    default: base = 16'h1800 + 16'(8 * (sel % 32));
                endcase
                if ($urandom % 4 != 0) base = base | 16'h0004;
                wr_addr = base;
                wr_data = $urandom;
                if ($urandom % 2 == 0) wr_data[10:6] = 5'd0;
                if ($urandom % 3 == 0) wr_data[31] = 1'b0;
                wr_en = 1'b1;
            end
            tick();
            check("R4 random vs model", m_onehot());
        end
        wr_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule